// File: doc/BRIEF.md
# Divided Sync Clock Phase Aligner

The block divides the system clock by four to produce a sync clock, and it can move the rising edge of that sync clock earlier in steps of one system-clock cycle. A step shortens one sync period from four input cycles to three. Three sources can request a step:

- **Software:** a strobe sets a self-clearing request bit.
- **Hardware:** while a level enable is high, each rising edge of the sync input causes a step.
- **Automatic:** a closed loop advances the phase until the block's own rising edge lines up with a master sync clock that arrives on the sync input.

Several devices that share one system clock use it to bring their divided clocks into phase. A slave runs in automatic mode and reports lock. Software or board logic can also nudge the phase by hand.

The sync input always passes through a two-flop synchronizer and a rising-edge detector before any mode uses it.

When more than one mode is enabled, only one source is honoured. Automatic mode wins over hardware mode, and hardware mode wins over software mode.

Top module: `sync_clk_aligner`

## Requirements
- R1: After reset, sync_clk_o is low, locked_o is low and sw_adv_o is low. With no advance, sync_clk_o repeats low for 2 cycles and then high for 2 cycles, a period of 4 system-clock cycles.
- R2: A one-cycle pulse on sw_adv_wr_i sets sw_adv_o high for exactly the next cycle. The bit then clears by itself.
- R3: Each cycle in which sw_adv_o is high, with neither other mode enabled, advances the next sync_clk_o rising edge by one system-clock cycle. N advances need N writes.
- R4: While hw_en_i is high and auto_en_i is low, each rising edge of sync_in_i advances sync_clk_o by one cycle. The step is applied 2 cycles after the edge is sampled, once the input has passed the two synchronizer flops.
- R5: hw_en_i is a level and does not clear itself. Once it is low, edges on sync_in_i cause no advance.
- R6: While auto_en_i is high, each detected rising edge of sync_in_i at which the phase is misaligned causes exactly one advance. No advance happens at any other time.
- R7: Aligned means that sync_clk_o rises at the same clock edge after which sync_in_i rises. locked_o is updated at each detected sync edge in automatic mode and is high when the phase is aligned. locked_o is low one cycle after auto_en_i is low.
- R8: Automatic mode has priority over hardware mode, and hardware mode has priority over software mode. A lower-priority request is dropped while a higher mode is enabled.
- R9: With every mode disabled and no software write, sync_in_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_in_i | input | 1 | External sync input (master sync clock or hardware step edges) |
| auto_en_i | input | 1 | Automatic alignment enable |
| hw_en_i | input | 1 | Hardware step enable (level) |
| sw_adv_wr_i | input | 1 | Write strobe that sets the self-clearing software step bit |
| sync_clk_o | output | 1 | Divided sync clock, one quarter of clk_i |
| locked_o | output | 1 | Automatic-mode phase lock flag |
| sw_adv_o | output | 1 | Readback of the self-clearing software step bit |

## Verification
The assertions check these on every cycle:
- The counter moves by one or two steps, and two steps only where an advance was requested.
- The software bit clears itself.
- A hardware-mode edge always produces a step.
- Automatic-mode steps occur only on detected sync edges.
- The lock flag falls when automatic mode is off.

Some behaviour can only be shown by the bench's scenarios against its behavioural model. This covers the exact cycle at which the edge moves after each kind of request, the dropped requests under mode priority, the absence of any effect from sync_in_i when all modes are off, and convergence to lock from a misaligned master.

// File: rtl/sync_aligner_pkg.sv
package sync_aligner_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_AUTO = 2'd1,
    SRC_HW   = 2'd2,
    SRC_SW   = 2'd3
  } adv_src_e;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/div_phase_cnt.sv
module div_phase_cnt #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             clk_o
);
  localparam logic [DIV_W-1:0] STEP_ONE = DIV_W'(1);
  localparam logic [DIV_W-1:0] STEP_ADV = DIV_W'(2);

  logic [DIV_W-1:0] cnt_q;

  // advance = skip one count, shortening the current period by one input cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + (adv_i ? STEP_ADV : STEP_ONE);
  end

  assign cnt_o = cnt_q;
  assign clk_o = cnt_q[DIV_W-1];

  // R3: counter moves two steps only after an advance request
  a_r3_step_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (DIV_W'(cnt_q - $past(cnt_q)) == ($past(adv_i) ? STEP_ADV : STEP_ONE)));
endmodule

// File: rtl/adv_arbiter.sv
module adv_arbiter
  import sync_aligner_pkg::*;
#(
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic             hw_en_i,
  input  logic             sw_pend_i,
  input  logic             rise_i,
  input  logic [DIV_W-1:0] cnt_i,
  output logic             adv_o,
  output logic             locked_o
);
  // counter value seen at a detected edge when phases coincide
  localparam int               TGT_INT = ((1 << (DIV_W-1)) + SYNC_STAGES) % (1 << DIV_W);
  localparam logic [DIV_W-1:0] TGT     = DIV_W'(TGT_INT);

  adv_src_e src;
  logic     aligned;
  logic     lock_q;

  assign aligned = (cnt_i == TGT);

  always_comb begin
    if (auto_en_i)    src = SRC_AUTO;
    else if (hw_en_i) src = SRC_HW;
    else if (sw_pend_i) src = SRC_SW;
    else              src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_AUTO: adv_o = rise_i & ~aligned;
      SRC_HW:   adv_o = rise_i;
      SRC_SW:   adv_o = 1'b1;
      default:  adv_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= 1'b0;
    else if (!auto_en_i) lock_q <= 1'b0;
    else if (rise_i)    lock_q <= aligned;
  end

  assign locked_o = lock_q;

  // R4: hardware-mode edge always steps
  a_r4_hw_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_en_i && !auto_en_i && rise_i) |-> adv_o);
  // R6: automatic steps only on detected edges
  a_r6_auto_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && adv_o) |-> rise_i);
  // R7: lock drops once automatic mode is off
  a_r7_lock_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> !locked_o);
  // R9: no source, no step
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i && !hw_en_i && !sw_pend_i) |-> !adv_o);
endmodule

// File: rtl/sync_clk_aligner.sv
module sync_clk_aligner #(
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_in_i,
  input  logic auto_en_i,
  input  logic hw_en_i,
  input  logic sw_adv_wr_i,
  output logic sync_clk_o,
  output logic locked_o,
  output logic sw_adv_o
);
  logic             sw_pend_q;
  logic             rise;
  logic             adv;
  logic [DIV_W-1:0] cnt;

  // self-clearing: holds one cycle per write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_pend_q <= 1'b0;
    else         sw_pend_q <= sw_adv_wr_i;
  end

  assign sw_adv_o = sw_pend_q;

  sync_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_in_i),
    .rise_o(rise)
  );

  adv_arbiter #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .auto_en_i(auto_en_i),
    .hw_en_i  (hw_en_i),
    .sw_pend_i(sw_pend_q),
    .rise_i   (rise),
    .cnt_i    (cnt),
    .adv_o    (adv),
    .locked_o (locked_o)
  );

  div_phase_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .cnt_o (cnt),
    .clk_o (sync_clk_o)
  );

  // R2: software bit clears itself unless rewritten
  a_r2_sw_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_adv_o && !sw_adv_wr_i) |=> !sw_adv_o);
  // R8: software step dropped while a higher mode is on
  a_r8_sw_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_adv_o && !rise && (auto_en_i || hw_en_i)) |-> !adv);
endmodule

// File: tb/sync_clk_aligner_bench.sv
module sync_clk_aligner_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_in = 1'b0, auto_en = 1'b0, hw_en = 1'b0, sw_wr = 1'b0;
  logic sync_clk, locked, sw_adv;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_ph = 0;
  bit m_lock = 0, m_sw = 0;
  bit hist[$] = '{0, 0, 0};
  bit master_run = 0;
  int master_ph = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_clk_aligner u_sync_clk_aligner (
    .clk_i(clk), .rst_ni(rst_ni), .sync_in_i(sync_in), .auto_en_i(auto_en),
    .hw_en_i(hw_en), .sw_adv_wr_i(sw_wr), .sync_clk_o(sync_clk),
    .locked_o(locked), .sw_adv_o(sw_adv)
  );

  always @(posedge clk) begin
    bit rise, adv;
    if (!rst_ni) begin
      m_ph = 0; m_lock = 0; m_sw = 0; hist = '{0, 0, 0};
    end else begin
      rise = hist[1] && !hist[2];
      if (auto_en)    adv = rise && (m_ph != 0);
      else if (hw_en) adv = rise;
      else            adv = m_sw;
      if (!auto_en)  m_lock = 0;
      else if (rise) m_lock = (m_ph == 0);
      m_ph = (m_ph + (adv ? 2 : 1)) % 4;
      m_sw = sw_wr;
      hist.push_front(sync_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(bit got, bit exp, string req, string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b t=%0t", req, what, got, exp, $time);
    end
  endtask

  // per-cycle compare, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      check(sync_clk, m_ph >= 2, cur_req, "sync_clk");
      check(locked, m_lock, cur_req, "locked");
      check(sw_adv, m_sw, cur_req, "sw_adv");
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (master_run) begin
        master_ph = (master_ph + 1) % 4;
        sync_in = (master_ph >= 2);
      end
    end
  endtask

  task automatic sync_pulses(int n);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'b1; tick(2);
      sync_in = 1'b0; tick(3);
    end
  endtask

  task automatic sw_write();
    sw_wr = 1'b1; tick(1); sw_wr = 1'b0;
  endtask

  initial begin
    tick(3);
    // R1 reset state
    check(sync_clk, 1'b0, "R1", "reset sync_clk");
    check(locked, 1'b0, "R1", "reset locked");
    check(sw_adv, 1'b0, "R1", "reset sw_adv");
    rst_ni = 1'b1;
    cur_req = "R1"; tick(12);
    cur_req = "R9"; sync_pulses(4);
    cur_req = "R2"; sw_write();
    check(sw_adv, 1'b1, "R2", "readback after write");
    tick(1);
    check(sw_adv, 1'b0, "R2", "self-clear");
    cur_req = "R3"; tick(6);
    sw_write(); sw_write(); tick(6);
    sw_write(); tick(3); sw_write(); tick(8);
    cur_req = "R4"; hw_en = 1'b1; tick(2);
    sync_pulses(3); sync_in = 1'b1; tick(1); sync_in = 1'b0; tick(6);
    cur_req = "R8"; sw_write(); tick(5); sync_pulses(1);
    cur_req = "R5"; hw_en = 1'b0; tick(2); sync_pulses(4);
    cur_req = "R6"; master_ph = 1; master_run = 1; auto_en = 1'b1;
    tick(40);
    check(locked, 1'b1, "R7", "locked after convergence");
    cur_req = "R8"; hw_en = 1'b1; sw_write(); tick(16);
    check(locked, 1'b1, "R8", "lock kept with hw and sw requests");
    cur_req = "R7"; auto_en = 1'b0; tick(1);
    check(locked, 1'b0, "R7", "lock clear after disable");
    hw_en = 1'b0; tick(2);
    master_ph = 3; auto_en = 1'b1; cur_req = "R6"; tick(30);
    check(locked, 1'b1, "R7", "relock from second offset");
    master_run = 0; auto_en = 1'b0; tick(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule